// File: doc/BRIEF.md
# Debounced Manual Power-On Trigger Detector

This block watches a manual trigger pin that is driven asynchronously, for example by a momentary switch to the supply rail. It decides when activity on that pin is a genuine manual power-on request. The pin is brought into the tick clock domain through a two-flop synchroniser. It is then filtered so that a change in either direction only counts once it has been steady for a set number of ticks. Finally, a qualifier accepts the press only when the filtered level has been high for enough ticks inside a bounded observation window. With the default parameters and a 1 ms tick, the press must be high for 20 ticks within a 30-tick window.

On an accepted press the block pulses a strobe that the gating controller uses as its drive-on request. It also raises a level flag that stays high for as long as the switch is held, which lets the controller stretch the on-time. On release it pulses a counter-clear so that the interval counters restart from zero. A press that begins while the drive is already on is ignored. A press that begins while the configuration step is busy raises an abort level until the switch is let go, and then pulses a restart so that configuration can run again. In one-shot operation each accepted press therefore yields exactly one further drive request.

Top module: `mpo_trigger`

## Requirements
- R1: A change of the synchronised pin that lasts fewer than DEB_TICKS (default 4) ticks, whether high or low, has no effect on any output.
- R2: A press is accepted when the filtered level has been high on HOLD_TICKS (default 20) samples counted from its first filtered high sample. The high samples may be separated by low gaps, as long as the total is reached before the window closes. A single raw pulse of HOLD_TICKS ticks is accepted and one of HOLD_TICKS-1 ticks is not.
- R3: When WINDOW_TICKS (default 30) samples have been taken since the first filtered high sample without reaching HOLD_TICKS high samples, the press is rejected and produces no strobe.
- R4: `press_stb` is high for exactly one cycle per accepted press. It rises DEB_TICKS+HOLD_TICKS+2 cycles after the raw pin rises on a clean press, in the same cycle as validation, so the drive request follows validation by zero ticks (well within 10 ms).
- R5: `held_hi` rises together with `press_stb` and stays high while the filtered pin stays high, however long that is.
- R6: `cnt_clr` is a one-cycle pulse issued when the filtered pin falls after an accepted press, in the cycle that `held_hi` falls. It is never issued for a rejected or ignored press.
- R7: If `drive_on` is 1 when the filtered pin rises, the press is ignored: no `press_stb`, no `held_hi` and no `cnt_clr` occur.
- R8: If `cfg_busy` is 1 when the filtered pin rises (this check takes priority over R7), `cfg_abort` is held high until the filtered pin falls and no strobe is issued. A one-cycle `cfg_restart` then follows in the cycle that `cfg_abort` falls.
- R9: While `rst_n` is 0 and after its release, with the pin low, all outputs are 0.
- R10: After a rejected press, a new qualification starts only once the filtered pin has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_pin | input | 1 | Asynchronous manual trigger pin, high means pressed |
| drive_on | input | 1 | 1 while the gated supply is already switched on |
| cfg_busy | input | 1 | 1 while the configuration step is in progress |
| press_stb | output | 1 | One-cycle strobe for an accepted press (drive-on request) |
| held_hi | output | 1 | High from acceptance until the filtered pin is released |
| cnt_clr | output | 1 | One-cycle interval-counter clear on release of an accepted press |
| cfg_abort | output | 1 | High while a press that began during configuration is held |
| cfg_restart | output | 1 | One-cycle request to restart configuration after an aborting press |

## Verification
The assertions assume that `drive_on` and `cfg_busy` are synchronous to the tick clock. They also assume that the default parameters hold, with HOLD_TICKS below WINDOW_TICKS and DEB_TICKS of at least two, so that the qualifier can never accept and reject in the same cycle. The stimulus changes `trig_pin`, `drive_on` and `cfg_busy` only on falling clock edges. It sets `drive_on` and `cfg_busy` well before a press and clears them only after the outputs have returned to rest. It also spaces presses so that the release of one press has fully passed through the filter before the next press begins.

// File: rtl/mpo_pkg.sv
// Package: shared types for the manual power-on trigger detector.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package mpo_pkg;

    // Qualifier states
    typedef enum logic [2:0] {
        MP_IDLE     = 3'd0,
        MP_WATCH    = 3'd1,
        MP_HELD     = 3'd2,
        MP_WAIT_LOW = 3'd3,
        MP_CFG_HOLD = 3'd4
    } mp_state_e;

endpackage

// File: rtl/mpo_sync.sv
// Module: mpo_sync
// Brings an asynchronous level into the clock domain through STAGES flops.
// Assumes the input may change at any time; output latency is STAGES cycles.
module mpo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpo_debounce.sv
// Module: mpo_debounce
// Two-sided filter: the output follows the input only after the input has
// differed from it for DEB_TICKS consecutive samples.
// Assumes a synchronous input; both edges are delayed by DEB_TICKS cycles.
module mpo_debounce #(
    parameter int DEB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    localparam int CW = $clog2(DEB_TICKS + 1);

    logic [CW-1:0] run_cnt;
    logic          lvl_q;

    // Count consecutive samples that differ from the filtered level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            lvl_q   <= 1'b0;
        end else if (din != lvl_q) begin
            if (run_cnt == CW'(DEB_TICKS - 1)) begin
                lvl_q   <= din;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end else begin
            run_cnt <= '0;
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/mpo_qualify.sv
// Module: mpo_qualify
// Decides whether a filtered press is accepted, ignored, or aborts
// configuration, and produces the strobe, hold level and release pulses.
// Assumes a filtered, synchronous level with HOLD_TICKS < WINDOW_TICKS and
// HOLD_TICKS >= 2; drive_on and cfg_busy are sampled on the filtered rise.
module mpo_qualify
    import mpo_pkg::*;
#(
    parameter int HOLD_TICKS   = 20,
    parameter int WINDOW_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic drive_on,
    input  logic cfg_busy,
    output logic press_stb,
    output logic held_hi,
    output logic cnt_clr,
    output logic cfg_abort,
    output logic cfg_restart
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam int WW = $clog2(WINDOW_TICKS + 1);

    mp_state_e     state, state_n;
    logic [HW-1:0] hold_cnt, hold_n;
    logic [WW-1:0] win_cnt, win_n;
    logic          stb_q, stb_n;
    logic          clr_q, clr_n;
    logic          rs_q, rs_n;

    // Next-state and counter decisions for one sample
    always_comb begin
        state_n = state;
        hold_n  = hold_cnt;
        win_n   = win_cnt;
        stb_n   = 1'b0;
        clr_n   = 1'b0;
        rs_n    = 1'b0;
        case (state)
            MP_IDLE: begin
                if (level) begin
                    if (cfg_busy) begin
                        state_n = MP_CFG_HOLD;
                    end else if (drive_on) begin
                        state_n = MP_WAIT_LOW;
                    end else begin
                        state_n = MP_WATCH;
                        hold_n  = HW'(1);
                        win_n   = WW'(1);
                    end
                end
            end
            MP_WATCH: begin
                if (level && hold_cnt == HW'(HOLD_TICKS - 1)) begin
                    state_n = MP_HELD;
                    stb_n   = 1'b1;
                end else if (win_cnt == WW'(WINDOW_TICKS - 1)) begin
                    state_n = level ? MP_WAIT_LOW : MP_IDLE;
                end else begin
                    win_n  = win_cnt + 1'b1;
                    hold_n = hold_cnt + HW'(level);
                end
            end
            MP_HELD: begin
                if (!level) begin
                    state_n = MP_IDLE;
                    clr_n   = 1'b1;
                end
            end
            MP_WAIT_LOW: begin
                if (!level) state_n = MP_IDLE;
            end
            MP_CFG_HOLD: begin
                if (!level) begin
                    state_n = MP_IDLE;
                    rs_n    = 1'b1;
                end
            end
            default: state_n = MP_IDLE;
        endcase
    end

    // Register state, counters and pulse outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= MP_IDLE;
            hold_cnt <= '0;
            win_cnt  <= '0;
            stb_q    <= 1'b0;
            clr_q    <= 1'b0;
            rs_q     <= 1'b0;
        end else begin
            state    <= state_n;
            hold_cnt <= hold_n;
            win_cnt  <= win_n;
            stb_q    <= stb_n;
            clr_q    <= clr_n;
            rs_q     <= rs_n;
        end
    end

    assign press_stb   = stb_q;
    assign held_hi     = (state == MP_HELD);
    assign cnt_clr     = clr_q;
    assign cfg_abort   = (state == MP_CFG_HOLD);
    assign cfg_restart = rs_q;
endmodule

// File: rtl/mpo_trigger.sv
// Module: mpo_trigger (top)
// Manual power-on trigger detector: synchroniser, two-sided filter and
// press qualifier in series.
// Assumes clk is the tick clock and drive_on/cfg_busy are synchronous to it.
module mpo_trigger #(
    parameter int SYNC_STAGES  = 2,
    parameter int DEB_TICKS    = 4,
    parameter int HOLD_TICKS   = 20,
    parameter int WINDOW_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_pin,
    input  logic drive_on,
    input  logic cfg_busy,
    output logic press_stb,
    output logic held_hi,
    output logic cnt_clr,
    output logic cfg_abort,
    output logic cfg_restart
);
    logic pin_sync;
    logic pin_lvl;

    mpo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trig_pin),
        .dout  (pin_sync)
    );

    mpo_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_sync),
        .level (pin_lvl)
    );

    mpo_qualify #(
        .HOLD_TICKS   (HOLD_TICKS),
        .WINDOW_TICKS (WINDOW_TICKS)
    ) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (pin_lvl),
        .drive_on    (drive_on),
        .cfg_busy    (cfg_busy),
        .press_stb   (press_stb),
        .held_hi     (held_hi),
        .cnt_clr     (cnt_clr),
        .cfg_abort   (cfg_abort),
        .cfg_restart (cfg_restart)
    );
endmodule

// File: rtl/mpo_trigger_chk.sv
// Module: mpo_trigger_chk
// Protocol checks on the detector outputs, attached to every mpo_trigger.
// Assumes synchronous reset; all properties are disabled while it is low.
module mpo_trigger_chk (
    input logic clk,
    input logic rst_n,
    input logic press_stb,
    input logic held_hi,
    input logic cnt_clr,
    input logic cfg_abort,
    input logic cfg_restart
);
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        press_stb |=> !press_stb);                                   // R4
    AST_STB_WITH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        press_stb |-> held_hi);                                      // R5
    AST_HELD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_hi) |-> press_stb);                               // R5
    AST_CLR_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |-> ($past(held_hi) && !held_hi));                   // R6
    AST_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_abort && (held_hi || press_stb)));                     // R8
    AST_RESTART_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_restart |-> ($past(cfg_abort) && !cfg_abort));           // R8
endmodule

bind mpo_trigger mpo_trigger_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .press_stb   (press_stb),
    .held_hi     (held_hi),
    .cnt_clr     (cnt_clr),
    .cfg_abort   (cfg_abort),
    .cfg_restart (cfg_restart)
);

// File: tb/mpo_trigger_bench.sv
// Directed bench for mpo_trigger: one task per scenario, each self-checking.
module mpo_trigger_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEB  = 4;
    localparam int HOLD = 20;
    localparam int WIN  = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_pin = 1'b0;
    logic drive_on = 1'b0;
    logic cfg_busy = 1'b0;
    logic press_stb, held_hi, cnt_clr, cfg_abort, cfg_restart;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int stb_cnt = 0, clr_cnt = 0, rs_cnt = 0, stb_cyc = -1;
    bit held_seen = 0, abort_seen = 0;

    mpo_trigger #(
        .DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .WINDOW_TICKS(WIN)
    ) u_mpo_trigger (
        .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin),
        .drive_on(drive_on), .cfg_busy(cfg_busy),
        .press_stb(press_stb), .held_hi(held_hi), .cnt_clr(cnt_clr),
        .cfg_abort(cfg_abort), .cfg_restart(cfg_restart)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (press_stb)   begin stb_cnt++; stb_cyc = cyc; end
        if (cnt_clr)     clr_cnt++;
        if (cfg_restart) rs_cnt++;
        if (held_hi)     held_seen = 1;
        if (cfg_abort)   abort_seen = 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk);
        stb_cnt = 0; clr_cnt = 0; rs_cnt = 0; stb_cyc = -1;
        held_seen = 0; abort_seen = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_pin(input logic v, input int n);
        trig_pin = v;
        wait_cyc(n);
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk("R9 stb in reset", press_stb, 0);
        chk("R9 held in reset", held_hi, 0);
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R9 outputs after reset", {press_stb, held_hi, cnt_clr, cfg_abort, cfg_restart}, 0);
    endtask

    task automatic t_min_hold();
        int t0;
        clear_mon();
        drive_pin(1'b1, HOLD - 1);
        drive_pin(1'b0, 20);
        chk("R2 short press rejected", stb_cnt, 0);
        chk("R6 no clear for rejected", clr_cnt, 0);
        clear_mon();
        t0 = cyc;
        drive_pin(1'b1, HOLD);
        drive_pin(1'b0, 20);
        chk("R2 exact hold accepted", stb_cnt, 1);
        chk("R4 strobe latency", stb_cyc, t0 + DEB + HOLD + 2);
        chk("R6 single clear on release", clr_cnt, 1);
        chk("R5 held returns low", held_hi, 0);
    endtask

    task automatic t_glitch();
        clear_mon();
        drive_pin(1'b1, DEB - 1);
        drive_pin(1'b0, 20);
        chk("R1 high glitch strobe", stb_cnt, 0);
        chk("R1 high glitch held", held_seen, 0);
        clear_mon();
        drive_pin(1'b1, 40);
        drive_pin(1'b0, DEB - 2);
        drive_pin(1'b1, 10);
        chk("R1 low glitch no clear", clr_cnt, 0);
        chk("R1 low glitch keeps held", held_hi, 1);
        drive_pin(1'b0, 20);
        chk("R4 one strobe per press", stb_cnt, 1);
        chk("R6 one clear after glitchy hold", clr_cnt, 1);
    endtask

    task automatic t_long_hold();
        clear_mon();
        drive_pin(1'b1, 150);
        chk("R5 held during long press", held_hi, 1);
        chk("R4 one strobe on long press", stb_cnt, 1);
        chk("R6 no clear while held", clr_cnt, 0);
        drive_pin(1'b0, 20);
        chk("R5 held released", held_hi, 0);
        chk("R6 clear after long press", clr_cnt, 1);
    endtask

    task automatic t_bouncy_ok();
        clear_mon();
        drive_pin(1'b1, 12);
        drive_pin(1'b0, 8);
        drive_pin(1'b1, 12);
        drive_pin(1'b0, 20);
        chk("R2 split press accepted", stb_cnt, 1);
        chk("R6 split press clear", clr_cnt, 1);
    endtask

    task automatic t_window();
        clear_mon();
        drive_pin(1'b1, 12);
        drive_pin(1'b0, 12);
        drive_pin(1'b1, 30);
        chk("R3 window expiry rejects", stb_cnt, 0);
        chk("R10 no new watch while high", held_seen, 0);
        drive_pin(1'b0, 20);
        chk("R3 no clear after reject", clr_cnt, 0);
        clear_mon();
        drive_pin(1'b1, 25);
        drive_pin(1'b0, 20);
        chk("R10 fresh press after release", stb_cnt, 1);
    endtask

    task automatic t_drive_on();
        clear_mon();
        drive_on = 1'b1;
        drive_pin(1'b1, 40);
        drive_pin(1'b0, 20);
        chk("R7 strobe suppressed", stb_cnt, 0);
        chk("R7 held suppressed", held_seen, 0);
        chk("R7 clear suppressed", clr_cnt, 0);
        drive_on = 1'b0;
        clear_mon();
        drive_pin(1'b1, 25);
        drive_pin(1'b0, 20);
        chk("R7 accepted once drive off", stb_cnt, 1);
    endtask

    task automatic t_cfg();
        clear_mon();
        cfg_busy = 1'b1;
        drive_on = 1'b1;
        drive_pin(1'b1, 40);
        chk("R8 abort level while held", cfg_abort, 1);
        chk("R8 no restart yet", rs_cnt, 0);
        drive_pin(1'b0, 20);
        chk("R8 no strobe during config", stb_cnt, 0);
        chk("R8 one restart on release", rs_cnt, 1);
        chk("R8 abort cleared", cfg_abort, 0);
        chk("R8 no clear for abort", clr_cnt, 0);
        cfg_busy = 1'b0;
        drive_on = 1'b0;
    endtask

    initial begin
        t_reset();
        t_min_hold();
        t_glitch();
        t_long_hold();
        t_bouncy_ok();
        t_window();
        t_drive_on();
        t_cfg();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule